// File: doc/BRIEF.md
# I2C Register Access Slave

This block is a slave on a two-wire I2C-compatible bus. It lets a host controller read and write a small register file that lives outside the block. SCL and SDA are sampled by a system clock that runs at least eight times faster than SCL. The block finds start, repeated-start and stop conditions in the sampled lines and answers one 7-bit device address. The two low bits of that address come from a select input, so four copies can share one bus. The block pulls SDA low through an open-drain enable and never drives it high.

A write transaction carries the device address with R/W = 0, then one subaddress byte, then any number of data bytes. Each data byte goes out on the register port as a one-cycle write strobe, and the register pointer advances after every byte. A read first sets the pointer with a write of the subaddress alone. The host then issues a repeated start with R/W = 1 and clocks out data until it answers a byte with not-acknowledge. Any sequence the block does not expect sends it back to idle. This covers a start or stop in the middle of a byte, an unknown subaddress, and a pointer that has run past the last register.

Top module: `i2c_regport`

## Requirements
- R1: A start condition (SDA falls while SCL is high) is required before any byte is decoded. From idle, bits clocked without a start are never acknowledged. A stop condition (SDA rises while SCL is high) always returns the block to idle with SDA released.
- R2: The first byte after a start is taken MSB first as a 7-bit address followed by R/W (bit 0, 1 = read). The block acknowledges by holding SDA low during the ninth SCL pulse only when address bits [7:1] equal `{BASE_ADDR[6:2], addr_sel}`. On a mismatch it leaves SDA released and ignores the bus until the next start.
- R3: In a write, the byte after the address is the subaddress and each following byte is data. Every accepted data byte is acknowledged and produces exactly one single-cycle `reg_we` pulse, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte.
- R4: The pointer increments after each data byte written, so a burst fills consecutive registers.
- R5: After the subaddress is written, a repeated start with R/W = 1 returns register data MSB first, starting at the subaddress. Each master-acknowledged byte is followed by the next register.
- R6: During a read, the block releases SDA for the master's acknowledge bit. A master not-acknowledge ends the read, and the block ignores the bus until the next start or stop.
- R7: A subaddress of `NUM_REGS` or above is not acknowledged. The block returns to idle, and data bytes sent after it are neither acknowledged nor written.
- R8: When a write burst has passed register `NUM_REGS-1`, the next data byte is not acknowledged and no further writes happen until a new transaction. The pointer does not wrap.
- R9: When a read burst has passed register `NUM_REGS-1`, the block returns 0x00 for every further byte.
- R10: A start condition seen after the second SCL rising edge of a byte, or during an acknowledge or a transmitted byte, sends the block to idle. The bits that follow are ignored until a fresh start.
- R11: A stop in the middle of a data byte discards the partial byte, and no write takes place.
- R12: After reset and whenever idle, SDA is released. The block starts pulling SDA low only while the sampled SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain enable) |
| addr_sel | input | 2 | Selects the two low device address bits |
| reg_addr | output | AW (4) | Register pointer, used for both reads and writes |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data for `reg_addr`, combinational from the register file |

## Verification
The hardest states to reach are the protocol violations, because a well-behaved master never produces them. These are a start condition in the middle of a byte, a stop that cuts a data byte short, and bits clocked after the block has given up on a transaction. The bench drives a bit-level master model whose start, stop and single-bit tasks can be mixed freely. It sends a few bits of a data byte and then issues a start or a stop. It then clocks a full byte with no start in front of it and checks that this byte draws no acknowledge and no write strobe. The pointer-overflow paths are reached by aiming a burst at the last register and running past it, in both the write and the read direction.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } eng_state_t;

  typedef enum logic [1:0] {
    BY_ADDR,
    BY_SUB,
    BY_DATA
  } byte_kind_t;

  // Device address compare: upper five bits fixed, lower two from the pins.
  function automatic logic addr_hit(input logic [7:0] rx_byte,
                                    input logic [6:0] base,
                                    input logic [1:0] sel);
    return rx_byte[7:1] == {base[6:2], sel};
  endfunction

  // Subaddress range check against the implemented register count.
  function automatic logic sub_in_range(input logic [7:0] rx_byte, input int n);
    return int'(rx_byte) < n;
  endfunction

  // A start is part of the normal flow only from idle, after a refused
  // transfer, or while the first bit of a received byte is on the bus.
  function automatic logic start_allowed(input eng_state_t st, input logic [3:0] bits);
    return (st == ST_IDLE) || (st == ST_WAIT) || ((st == ST_RX) && (bits <= 4'd1));
  endfunction

endpackage

// File: rtl/i2c_regport_sync.sv
module i2c_regport_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_evt = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/i2c_regport_ptr.sv
module i2c_regport_ptr #(
  parameter int NUM_REGS = 16,
  parameter int AW       = 4,
  parameter int PW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sub_load,
  input  logic [7:0]    sub_val,
  input  logic          ptr_step,
  input  logic          wr_req,
  input  logic [7:0]    wr_data,
  output logic          ptr_valid,
  output logic [AW-1:0] reg_addr,
  output logic          reg_we,
  output logic [7:0]    reg_wdata
);

  localparam logic [PW-1:0] LIMIT = PW'(NUM_REGS);

  logic [PW-1:0] ptr;

  // Saturates one past the last register so that overflow is sticky.
  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == LIMIT) ? p : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_we <= wr_req;
      if (wr_req) reg_wdata <= wr_data;
      if (sub_load)                ptr <= PW'(sub_val);
      else if (ptr_step || reg_we) ptr <= ptr_next(ptr);
    end
  end

  assign ptr_valid = ptr < LIMIT;
  assign reg_addr  = ptr[AW-1:0];

endmodule

// File: rtl/i2c_regport_eng.sv
module i2c_regport_eng
  import i2c_regport_pkg::*;
#(
  parameter int         NUM_REGS  = 16,
  parameter logic [6:0] BASE_ADDR = 7'h38
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [1:0] addr_sel,
  input  logic       ptr_valid,
  input  logic [7:0] reg_rdata,
  output logic       sda_oe,
  output logic       sub_load,
  output logic [7:0] sub_val,
  output logic       ptr_step,
  output logic       wr_req,
  output logic [7:0] wr_data,
  output logic       eng_idle,
  output logic       rx_mid
);

  eng_state_t state;
  byte_kind_t kind;
  byte_kind_t next_kind;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic       go_tx;
  logic [7:0] tx_byte;
  logic       byte_end;

  assign tx_byte  = ptr_valid ? reg_rdata : 8'h00;
  assign byte_end = scl_fall && (bitcnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      kind      <= BY_ADDR;
      next_kind <= BY_ADDR;
      bitcnt    <= '0;
      shreg     <= '0;
      go_tx     <= 1'b0;
      sda_oe    <= 1'b0;
      sub_load  <= 1'b0;
      ptr_step  <= 1'b0;
      wr_req    <= 1'b0;
    end else begin
      sub_load <= 1'b0;
      ptr_step <= 1'b0;
      wr_req   <= 1'b0;
      if (stop_evt) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_evt) begin
        sda_oe <= 1'b0;
        bitcnt <= '0;
        kind   <= BY_ADDR;
        state  <= start_allowed(state, bitcnt) ? ST_RX : ST_IDLE;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_lvl};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_end) begin
              bitcnt <= '0;
              case (kind)
                BY_ADDR: begin
                  if (addr_hit(shreg, BASE_ADDR, addr_sel)) begin
                    sda_oe    <= 1'b1;
                    state     <= ST_ACK;
                    go_tx     <= shreg[0];
                    next_kind <= BY_SUB;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                BY_SUB: begin
                  if (sub_in_range(shreg, NUM_REGS)) begin
                    sda_oe    <= 1'b1;
                    state     <= ST_ACK;
                    go_tx     <= 1'b0;
                    next_kind <= BY_DATA;
                    sub_load  <= 1'b1;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                default: begin
                  if (ptr_valid) begin
                    sda_oe    <= 1'b1;
                    state     <= ST_ACK;
                    go_tx     <= 1'b0;
                    next_kind <= BY_DATA;
                    wr_req    <= 1'b1;
                  end else begin
                    state <= ST_WAIT;
                  end
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (go_tx) begin
                state    <= ST_TX;
                shreg    <= tx_byte;
                sda_oe   <= ~tx_byte[7];
                ptr_step <= 1'b1;
              end else begin
                state  <= ST_RX;
                kind   <= next_kind;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_end) begin
              state  <= ST_MACK;
              sda_oe <= 1'b0;
              bitcnt <= '0;
            end else if (scl_fall) begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              if (sda_lvl) state <= ST_WAIT;
            end else if (scl_fall) begin
              state    <= ST_TX;
              shreg    <= tx_byte;
              sda_oe   <= ~tx_byte[7];
              ptr_step <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sub_val  = shreg;
  assign wr_data  = shreg;
  assign eng_idle = (state == ST_IDLE);
  assign rx_mid   = (state == ST_RX) && (bitcnt >= 4'd2);

endmodule

// File: rtl/i2c_regport.sv
module i2c_regport #(
  parameter int         NUM_REGS    = 16,
  parameter logic [6:0] BASE_ADDR   = 7'h38,
  parameter int         SYNC_STAGES = 2,
  localparam int        AW          = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int        PW          = $clog2(NUM_REGS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [1:0]    addr_sel,
  output logic [AW-1:0] reg_addr,
  output logic          reg_we,
  output logic [7:0]    reg_wdata,
  input  logic [7:0]    reg_rdata
);

  logic       scl_lvl;
  logic       sda_lvl;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_evt;
  logic       stop_evt;
  logic       sub_load;
  logic [7:0] sub_val;
  logic       ptr_step;
  logic       wr_req;
  logic [7:0] wr_data;
  logic       ptr_valid;
  logic       eng_idle;
  logic       rx_mid;

  i2c_regport_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_regport_eng #(.NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .addr_sel(addr_sel), .ptr_valid(ptr_valid), .reg_rdata(reg_rdata),
    .sda_oe(sda_oe), .sub_load(sub_load), .sub_val(sub_val),
    .ptr_step(ptr_step), .wr_req(wr_req), .wr_data(wr_data),
    .eng_idle(eng_idle), .rx_mid(rx_mid)
  );

  i2c_regport_ptr #(.NUM_REGS(NUM_REGS), .AW(AW), .PW(PW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .sub_load(sub_load), .sub_val(sub_val),
    .ptr_step(ptr_step), .wr_req(wr_req), .wr_data(wr_data),
    .ptr_valid(ptr_valid), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata)
  );

endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_lvl,
  input logic scl_fall,
  input logic start_evt,
  input logic stop_evt,
  input logic sda_oe,
  input logic reg_we,
  input logic eng_idle,
  input logic rx_mid
);

  AST_DRIVE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl); // R12

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    eng_idle |-> !sda_oe); // R12

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (eng_idle && !sda_oe)); // R1

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we); // R3

  AST_WE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(scl_fall, 2)); // R3

  AST_MIDBYTE_START_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && rx_mid) |=> eng_idle); // R10

endmodule

bind i2c_regport i2c_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .scl_fall(scl_fall),
  .start_evt(start_evt), .stop_evt(stop_evt), .sda_oe(sda_oe),
  .reg_we(reg_we), .eng_idle(eng_idle), .rx_mid(rx_mid)
);

// File: tb/i2c_regport_test.sv
module i2c_regport_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] addr_sel = 2'b01;
  logic       sda_oe;
  logic [3:0] reg_addr;
  logic       reg_we;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  wire        sda_bus = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  int we_cnt = 0;
  int drv_viol = 0;
  logic [7:0] mem [16];
  logic [7:0] expv [16];
  logic       prev_oe = 1'b0;

  always #5 clk = ~clk;

  i2c_regport uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // register file model
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 8'h00;
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end
  end
  assign reg_rdata = mem[reg_addr];

  // R12 monitor: the drive may only change while the raw SCL is low
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== prev_oe) && scl) drv_viol = drv_viol + 1;
    prev_oe = sda_oe;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_bit(input logic b, output logic r);
    wclk(2); sda_m = b; wclk(6); scl = 1'b1; wclk(4); r = sda_bus; wclk(4); scl = 1'b0;
  endtask

  task automatic m_start();
    wclk(2); sda_m = 1'b1; wclk(6); scl = 1'b1; wclk(8); sda_m = 1'b0; wclk(8); scl = 1'b0;
  endtask

  task automatic m_stop();
    wclk(2); sda_m = 1'b0; wclk(6); scl = 1'b1; wclk(8); sda_m = 1'b1; wclk(8);
  endtask

  task automatic m_wbyte(input logic [7:0] v, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(v[i], r);
    m_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic m_rbyte(input logic ack_m, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, r);
      v[i] = r;
    end
    m_bit(~ack_m, r);
  endtask

  // {address byte, subaddress, data, expected acks addr/sub/data}
  localparam int NV = 6;
  localparam logic [26:0] VEC [NV] = '{
    {8'h72, 8'h00, 8'hA5, 3'b111},
    {8'h72, 8'h0F, 8'h3C, 3'b111},
    {8'h74, 8'h01, 8'h99, 3'b000},
    {8'h72, 8'h10, 8'h77, 3'b100},
    {8'h72, 8'h07, 8'h81, 3'b111},
    {8'h70, 8'h02, 8'h66, 3'b000}
  };

  initial begin : watchdog
    wclk(100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic a0, a1, a2, r;
    logic [7:0] d;
    int wsave;
    for (int i = 0; i < 16; i++) expv[i] = 8'h00;
    wclk(5);
    chk("R12 reset sda_oe", 32'(sda_oe), 0);
    chk("R3 reset reg_we", 32'(reg_we), 0);
    rst_n = 1'b1;
    wclk(5);

    // R1: no start, address byte ignored
    scl = 1'b0; wclk(4);
    m_wbyte(8'h72, a0);
    chk("R1 no ack without start", 32'(a0), 0);
    m_stop();

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [7:0] ab, sb, db;
      logic [2:0] ea;
      {ab, sb, db, ea} = VEC[v];
      m_start();
      m_wbyte(ab, a0);
      chk("R2 address ack", 32'(a0), 32'(ea[2]));
      if (a0) begin
        m_wbyte(sb, a1);
        chk("R7 subaddress ack", 32'(a1), 32'(ea[1]));
        if (a1) begin
          m_wbyte(db, a2);
          chk("R3 data ack", 32'(a2), 32'(ea[0]));
        end
      end
      m_stop();
      if (ea == 3'b111) expv[sb[3:0]] = db;
    end
    for (int i = 0; i < 16; i++) chk("R3 register contents", 32'(mem[i]), 32'(expv[i]));

    // R2: other select value moves the address
    addr_sel = 2'b10;
    m_start(); m_wbyte(8'h74, a0); m_wbyte(8'h01, a1); m_wbyte(8'h5A, a2); m_stop();
    chk("R2 sel=10 ack", 32'({a0, a1, a2}), 32'h7);
    chk("R2 sel=10 write", 32'(mem[1]), 32'h5A);
    expv[1] = 8'h5A;
    m_start(); m_wbyte(8'h72, a0); m_stop();
    chk("R2 old address refused", 32'(a0), 0);
    addr_sel = 2'b01;

    // R4: burst write
    m_start(); m_wbyte(8'h72, a0); m_wbyte(8'h03, a0);
    m_wbyte(8'h11, a0); m_wbyte(8'h22, a1); m_wbyte(8'h33, a2); m_stop();
    chk("R4 burst acks", 32'({a0, a1, a2}), 32'h7);
    chk("R4 reg3", 32'(mem[3]), 32'h11);
    chk("R4 reg4", 32'(mem[4]), 32'h22);
    chk("R4 reg5", 32'(mem[5]), 32'h33);

    // R5 read burst, R6 nack then ignored bits
    m_start(); m_wbyte(8'h72, a0); m_wbyte(8'h03, a1);
    m_start(); m_wbyte(8'h73, a2);
    chk("R5 read address ack", 32'({a0, a1, a2}), 32'h7);
    m_rbyte(1'b1, d); chk("R5 read byte0", 32'(d), 32'h11);
    m_rbyte(1'b1, d); chk("R5 read byte1", 32'(d), 32'h22);
    m_rbyte(1'b0, d); chk("R5 read byte2", 32'(d), 32'h33);
    m_wbyte(8'h72, a0);
    chk("R6 ignored after master nack", 32'(a0), 0);
    m_stop();

    // R8: write past the end
    wsave = we_cnt;
    m_start(); m_wbyte(8'h72, a0); m_wbyte(8'h0E, a0);
    m_wbyte(8'hD1, a0); m_wbyte(8'hD2, a1); m_wbyte(8'hD3, a2); m_stop();
    chk("R8 acks", 32'({a0, a1, a2}), 32'h6);
    chk("R8 reg14", 32'(mem[14]), 32'hD1);
    chk("R8 reg15", 32'(mem[15]), 32'hD2);
    chk("R8 no wrap", 32'(mem[0]), 32'(expv[0]));
    chk("R8 write count", 32'(we_cnt - wsave), 2);

    // R9: read past the end
    m_start(); m_wbyte(8'h72, a0); m_wbyte(8'h0F, a0);
    m_start(); m_wbyte(8'h73, a0);
    m_rbyte(1'b1, d); chk("R9 last reg", 32'(d), 32'hD2);
    m_rbyte(1'b1, d); chk("R9 beyond end", 32'(d), 32'h00);
    m_rbyte(1'b0, d); chk("R9 beyond end again", 32'(d), 32'h00);
    m_stop();

    // R7: out-of-range subaddress then data
    wsave = we_cnt;
    m_start(); m_wbyte(8'h72, a0); m_wbyte(8'h12, a1); m_wbyte(8'h44, a2); m_stop();
    chk("R7 sub nack", 32'(a1), 0);
    chk("R7 data nack", 32'(a2), 0);
    chk("R7 no write", 32'(we_cnt - wsave), 0);

    // R10: start in mid-byte aborts
    wsave = we_cnt;
    m_start(); m_wbyte(8'h72, a0); m_wbyte(8'h08, a0);
    m_bit(1'b1, r); m_bit(1'b0, r); m_bit(1'b1, r);
    m_start();
    m_wbyte(8'h72, a0);
    chk("R10 no ack after abort", 32'(a0), 0);
    m_wbyte(8'h55, a0);
    m_stop();
    chk("R10 no write", 32'(we_cnt - wsave), 0);
    chk("R10 reg8 kept", 32'(mem[8]), 32'(expv[8]));
    m_start(); m_wbyte(8'h72, a0); m_stop();
    chk("R10 recovers on new start", 32'(a0), 1);

    // R11: stop in mid data byte
    wsave = we_cnt;
    m_start(); m_wbyte(8'h72, a0); m_wbyte(8'h09, a0);
    for (int i = 0; i < 5; i++) m_bit(1'b0, r);
    m_stop();
    chk("R11 no partial write", 32'(we_cnt - wsave), 0);
    chk("R11 reg9 kept", 32'(mem[9]), 32'(expv[9]));
    chk("R1 idle after stop", 32'(sda_oe), 0);

    chk("R12 drive changes with SCL high", 32'(drv_viol), 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule